// File: doc/BRIEF.md
# SMBus Slave Port for 16-bit Configuration Registers

This block is a bus slave that exposes a small bank of 16-bit configuration registers over a two-wire SMBus/I2C-style link. The block runs on the system clock and oversamples the SCL and SDA lines through synchronizers. It detects Start and Stop conditions and answers only to its own 7-bit device address. It pulls SDA low through an open-drain enable to acknowledge bytes and to send read data. The block does not stretch the clock, does not arbitrate between masters and does not compute packet error codes.

Each register moves as two bytes, with the low byte first. A write carries the address byte with R/W=0, a pointer byte, the low data byte and the high data byte. The slave holds the received value and applies it only when the transaction closes. To read, the master first runs a write-mode transaction that carries only the pointer and ends with Stop. It then issues a new Start and sends the address byte with R/W=1. The slave answers with the low byte and then the high byte. Every register is presented on parallel outputs, and each register has a strobe that pulses for one clock when a write lands in it.

The byte sequencer uses these states:
- IDLE: the bus is free.
- ADDR: the address byte is being received.
- PTR: the pointer byte is being received.
- WLO and WHI: the low and high data bytes are being received.
- WEXTRA: surplus write bytes are refused.
- RLO and RHI: the low and high bytes are being sent.
- IGNORE: the slave waits for the next Start or Stop.

Transitions:
- Any Start leads to ADDR, and any Stop leads to IDLE.
- At the end of a byte's acknowledge clock, ADDR goes to PTR (own address, write), to RLO (own address, read) or to IGNORE (another address).
- PTR goes to WLO, WLO to WHI, WHI to WEXTRA, and WEXTRA stays in WEXTRA.
- RLO goes to RHI if the master acknowledged, otherwise to IGNORE.
- RHI goes to IGNORE.

Top module: `smb_reg_port`

## Requirements
- R1: After reset all registers read 0x0000, sda_oe is low and no write strobe is active.
- R2: The slave acknowledges an address byte only when its upper seven bits equal DEV_ADDR. To acknowledge, it drives SDA low during the ninth SCL clock. For any other address it drives nothing until the next Start or Stop.
- R3: In a write, the address, pointer, low and high bytes are each acknowledged, and the stored value is {high byte, low byte}. Bits travel MSB first within a byte.
- R4: A written value appears on reg_q only after the Stop that closes the transaction. Before that Stop the register keeps its previous value.
- R5: A write that ends before its high byte is complete leaves every register unchanged and raises no strobe.
- R6: Data bytes after the high byte are not acknowledged and are discarded. The committed value comes from the first two data bytes.
- R7: Each committed write to register i pulses wr_stb[i] high for exactly one clock, with no other strobe bit set. reg_q changes only in a cycle where a strobe is high.
- R8: A read returns the low byte first and the high byte second. The register is the one chosen by the pointer of the preceding write-mode transaction.
- R9: A write to a pointer that maps to no register is acknowledged in full and changes nothing. A read from such a pointer returns 0x0000.
- R10: Register i is selected by pointer byte REG_PTRS[8i+7:8i]. The defaults are 0x12, 0x14, 0x15, 0x3E and 0x3F for i = 0 to 4.
- R11: A repeated Start with no Stop before it commits a pending write as a Stop would, and then begins a new address phase.
- R12: A Start or Stop in the middle of a byte abandons that byte. A complete transaction that follows behaves normally.
- R13: If the master does not acknowledge the low read byte, the slave releases SDA and drives nothing more until the next Start or Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, the slave pulls SDA low |
| reg_q | output | NUM_REGS*16 | Register values; register i at bits [16i+15:16i] |
| wr_stb | output | NUM_REGS | One-cycle commit strobe per register |

## Verification
The bench writes distinct values to all five pointers and reads them back. This shows that pointer decoding and low-first byte order are correct, since a swapped byte order or an aliased pointer gives a different word. Several broken transactions are compared with the clean path:
- a foreign address,
- an unmapped pointer,
- a write cut after the low byte,
- a write with a third data byte,
- a Start that arrives mid-byte.

These show whether the slave commits only complete writes and only at Stop or at a repeated Start. A read whose low byte the master refuses shows whether the slave lets go of SDA. A behavioural model tracks pending and committed values and is compared with reg_q on every clock.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WLO,
        ST_WHI,
        ST_WEXTRA,
        ST_RLO,
        ST_RHI,
        ST_IGNORE
    } smb_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } smb_evt_t;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned WORD_BITS = 16;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output smb_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h09
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  smb_evt_t             evt,
    input  logic [WORD_BITS-1:0] rd_data,
    output logic                 sda_oe,
    output logic                 ptr_we,
    output logic [BYTE_BITS-1:0] ptr_byte,
    output logic                 commit,
    output logic [WORD_BITS-1:0] wdata
);

    localparam logic [3:0] CNT_DATA_DONE = 4'd8;
    localparam logic [3:0] CNT_ACK_DONE  = 4'd9;

    smb_state_e           state;
    smb_state_e           state_n;
    logic [3:0]           cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic [BYTE_BITS-1:0] tx;
    logic [BYTE_BITS-1:0] lo_q;
    logic                 pend;
    logic                 mack;
    logic                 addr_hit;
    logic                 active;
    logic                 sending;
    logic                 bus_cond;
    logic [2:0]           tx_idx;

    assign addr_hit = (shreg[7:1] == DEV_ADDR);
    assign active   = (state != ST_IDLE) && (state != ST_IGNORE);
    assign sending  = (state == ST_RLO) || (state == ST_RHI);
    assign bus_cond = evt.start | evt.stop;
    assign tx_idx   = 3'(7 - int'(cnt));
    assign ptr_byte = shreg;

    // next-state logic
    always_comb begin
        state_n = state;
        if (evt.start) begin
            state_n = ST_ADDR;
        end else if (evt.stop) begin
            state_n = ST_IDLE;
        end else if (evt.scl_fall && active && cnt == CNT_ACK_DONE) begin
            unique case (state)
                ST_ADDR:   state_n = !addr_hit ? ST_IGNORE
                                   : (shreg[0] ? ST_RLO : ST_PTR);
                ST_PTR:    state_n = ST_WLO;
                ST_WLO:    state_n = ST_WHI;
                ST_WHI:    state_n = ST_WEXTRA;
                ST_WEXTRA: state_n = ST_WEXTRA;
                ST_RLO:    state_n = mack ? ST_RHI : ST_IGNORE;
                ST_RHI:    state_n = ST_IGNORE;
                default:   state_n = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // bit counter, shift paths and line drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            shreg  <= '0;
            tx     <= '0;
            lo_q   <= '0;
            wdata  <= '0;
            pend   <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
            commit <= 1'b0;
            ptr_we <= 1'b0;
        end else begin
            commit <= 1'b0;
            ptr_we <= 1'b0;
            if (bus_cond) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                commit <= pend;
                pend   <= 1'b0;
            end else begin
                if (evt.scl_rise && active) begin
                    cnt <= cnt + 4'd1;
                    if (cnt < CNT_DATA_DONE) begin
                        shreg <= {shreg[BYTE_BITS-2:0], evt.sda};
                    end
                    if (cnt == CNT_DATA_DONE) begin
                        mack <= ~evt.sda;
                    end
                end
                if (evt.scl_fall && active) begin
                    if (cnt == CNT_DATA_DONE) begin
                        unique case (state)
                            ST_ADDR: sda_oe <= addr_hit;
                            ST_PTR: begin
                                sda_oe <= 1'b1;
                                ptr_we <= 1'b1;
                            end
                            ST_WLO: begin
                                sda_oe <= 1'b1;
                                lo_q   <= shreg;
                            end
                            ST_WHI: begin
                                sda_oe <= 1'b1;
                                wdata  <= {shreg, lo_q};
                                pend   <= 1'b1;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (cnt == CNT_ACK_DONE) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        if (state == ST_ADDR && state_n == ST_RLO) begin
                            tx     <= rd_data[7:0];
                            sda_oe <= ~rd_data[7];
                        end else if (state == ST_RLO && state_n == ST_RHI) begin
                            tx     <= rd_data[15:8];
                            sda_oe <= ~rd_data[15];
                        end
                    end else if (sending && cnt != 4'd0) begin
                        sda_oe <= ~tx[tx_idx];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_pkg::*;
#(
    parameter int unsigned                NUM_REGS = 5,
    parameter logic [NUM_REGS*8-1:0]      REG_PTRS = 40'h3F_3E_15_14_12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ptr_we,
    input  logic [BYTE_BITS-1:0]          ptr_byte,
    input  logic                          commit,
    input  logic [WORD_BITS-1:0]          wdata,
    output logic [WORD_BITS-1:0]          rd_data,
    output logic [NUM_REGS*WORD_BITS-1:0] reg_q,
    output logic [NUM_REGS-1:0]           wr_stb
);

    logic [BYTE_BITS-1:0] ptr;
    logic [NUM_REGS-1:0]  hit;
    logic [WORD_BITS-1:0] q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_we) begin
            ptr <= ptr_byte;
        end
    end

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            assign hit[i] = (ptr == REG_PTRS[i*8 +: 8]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[i]      <= '0;
                    wr_stb[i] <= 1'b0;
                end else begin
                    wr_stb[i] <= commit & hit[i];
                    if (commit && hit[i]) begin
                        q[i] <= wdata;
                    end
                end
            end

            assign reg_q[i*WORD_BITS +: WORD_BITS] = q[i];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) begin
                rd_data = rd_data | q[i];
            end
        end
    end

endmodule

// File: rtl/smb_reg_port.sv
module smb_reg_port
    import smb_pkg::*;
#(
    parameter logic [6:0]            DEV_ADDR    = 7'h09,
    parameter int unsigned           NUM_REGS    = 5,
    parameter logic [NUM_REGS*8-1:0] REG_PTRS    = 40'h3F_3E_15_14_12,
    parameter int unsigned           SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe,
    output logic [NUM_REGS*16-1:0]    reg_q,
    output logic [NUM_REGS-1:0]       wr_stb
);

    smb_evt_t             evt;
    logic [WORD_BITS-1:0] rd_data;
    logic [WORD_BITS-1:0] wdata;
    logic [BYTE_BITS-1:0] ptr_byte;
    logic                 ptr_we;
    logic                 commit;

    smb_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    smb_byte_fsm #(
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .ptr_we   (ptr_we),
        .ptr_byte (ptr_byte),
        .commit   (commit),
        .wdata    (wdata)
    );

    smb_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .REG_PTRS (REG_PTRS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_we   (ptr_we),
        .ptr_byte (ptr_byte),
        .commit   (commit),
        .wdata    (wdata),
        .rd_data  (rd_data),
        .reg_q    (reg_q),
        .wr_stb   (wr_stb)
    );

endmodule

// File: rtl/smb_reg_port_chk.sv
module smb_reg_port_chk #(
    parameter int unsigned NUM_REGS = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_i,
    input logic                   sda_oe,
    input logic [NUM_REGS*16-1:0] reg_q,
    input logic [NUM_REGS-1:0]    wr_stb
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (reg_q == '0 && !sda_oe && wr_stb == '0)); // R1

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb)); // R7

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |=> !(|wr_stb)); // R7

    AST_REG_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_q) |-> (|wr_stb)); // R4

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i); // R2

endmodule

bind smb_reg_port smb_reg_port_chk #(
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .reg_q  (reg_q),
    .wr_stb (wr_stb)
);

// File: tb/tb_smb_reg_port.sv
module tb_smb_reg_port;

    localparam int NR = 5;
    localparam int H  = 10;
    localparam logic [7:0] AW = 8'h12;
    localparam logic [7:0] AR = 8'h13;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl = 1'b1;
    logic            sda_m = 1'b1;
    logic            sda_oe;
    logic [NR*16-1:0] reg_q;
    logic [NR-1:0]   wr_stb;
    wire             sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int failures = 0;
    int mon_prints = 0;
    bit hold = 1'b1;
    bit done = 1'b0;

    logic [15:0] exp_q [NR];
    int          exp_stb [NR];
    int          stb_cnt [NR];
    bit          pend_ok = 1'b0;
    logic [7:0]  pend_ptr;
    logic [15:0] pend_val;

    always #10 clk = ~clk;

    smb_reg_port dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .reg_q  (reg_q),
        .wr_stb (wr_stb)
    );

    function automatic int idx_of(input logic [7:0] p);
        case (p)
            8'h12: return 0;
            8'h14: return 1;
            8'h15: return 2;
            8'h3E: return 3;
            8'h3F: return 4;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural model (R4, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NR; i++) stb_cnt[i] += int'(wr_stb[i]);
        end
        if (rst_n && !hold && !done) begin
            for (int i = 0; i < NR; i++) begin
                checks++;
                if (reg_q[i*16 +: 16] !== exp_q[i]) begin
                    failures++;
                    if (mon_prints < 8) begin
                        mon_prints++;
                        $display("FAIL R4 reg%0d actual=%h expected=%h", i, reg_q[i*16 +: 16], exp_q[i]);
                    end
                end
            end
        end
    end

    task automatic bw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_pend();
        if (pend_ok && idx_of(pend_ptr) >= 0) begin
            exp_q[idx_of(pend_ptr)] = pend_val;
            exp_stb[idx_of(pend_ptr)]++;
        end
        pend_ok = 1'b0;
    endtask

    task automatic bus_start();
        hold = 1'b1;
        sda_m = 1'b1; bw(H);
        scl = 1'b1;   bw(H);
        sda_m = 1'b0; bw(H);
        scl = 1'b0;   bw(H);
        apply_pend();
        hold = 1'b0;
    endtask

    task automatic bus_stop();
        hold = 1'b1;
        sda_m = 1'b0; bw(H);
        scl = 1'b1;   bw(H);
        sda_m = 1'b1; bw(H);
        apply_pend();
        hold = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; bw(H);
            scl = 1'b1;   bw(H);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; bw(H);
        scl = 1'b1;   bw(H/2);
        ack = ~sda_line;
        bw(H/2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bw(H);
            scl = 1'b1; bw(H/2);
            b[i] = sda_line;
            bw(H/2);
            scl = 1'b0;
        end
        bw(2);
        sda_m = give_ack ? 1'b0 : 1'b1;
        bw(H);
        scl = 1'b1; bw(H);
        scl = 1'b0; bw(2);
        sda_m = 1'b1;
    endtask

    // full write; acks packed as {addr,ptr,lo,hi}; stop_it=0 leaves the bus open
    task automatic write_reg(input logic [7:0] p, input logic [15:0] v,
                             input bit stop_it, output logic [3:0] acks);
        bit a;
        bus_start();
        send_byte(AW, a);      acks[3] = a;
        send_byte(p, a);       acks[2] = a;
        send_byte(v[7:0], a);  acks[1] = a;
        send_byte(v[15:8], a); acks[0] = a;
        pend_ok = 1'b1; pend_ptr = p; pend_val = v;
        if (stop_it) bus_stop();
    endtask

    task automatic read_reg(input logic [7:0] p, output logic [15:0] v);
        bit a;
        logic [7:0] lo;
        logic [7:0] hi;
        bus_start();
        send_byte(AW, a);
        send_byte(p, a);
        bus_stop();
        bus_start();
        send_byte(AR, a);
        recv_byte(1'b1, lo);
        recv_byte(1'b0, hi);
        bus_stop();
        v = {hi, lo};
    endtask

    task automatic finish_sim();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_sim();
    end

    initial begin
        logic [3:0]  acks;
        logic [15:0] v;
        logic [7:0]  b;
        bit          a;
        int          s0 [NR];
        for (int i = 0; i < NR; i++) begin
            exp_q[i] = '0; exp_stb[i] = 0; stb_cnt[i] = 0;
        end
        bw(5);
        rst_n = 1'b1;
        bw(3);
        // R1 reset state
        chk("R1 reg_q", 32'(reg_q == '0), 32'd1);
        chk("R1 sda_oe", 32'(sda_oe), 32'd0);
        chk("R1 wr_stb", 32'(wr_stb), 32'd0);
        hold = 1'b0;

        // R3 / R8 basic write and low-first read
        write_reg(8'h14, 16'h41A0, 1'b1, acks);
        chk("R3 acks", 32'(acks), 32'hF);
        chk("R3 value", 32'(reg_q[16 +: 16]), 32'h41A0);
        read_reg(8'h14, v);
        chk("R8 low byte first", 32'(v[7:0]), 32'hA0);
        chk("R8 high byte", 32'(v[15:8]), 32'h41);

        // R10 every pointer maps to its own register
        for (int i = 0; i < NR; i++) s0[i] = stb_cnt[i];
        write_reg(8'h12, 16'h1357, 1'b1, acks);
        write_reg(8'h15, 16'hBEEF, 1'b1, acks);
        write_reg(8'h3E, 16'h8001, 1'b1, acks);
        write_reg(8'h3F, 16'h00FF, 1'b1, acks);
        read_reg(8'h12, v); chk("R10 ptr 12", 32'(v), 32'h1357);
        read_reg(8'h15, v); chk("R10 ptr 15", 32'(v), 32'hBEEF);
        read_reg(8'h3E, v); chk("R10 ptr 3E", 32'(v), 32'h8001);
        read_reg(8'h3F, v); chk("R10 ptr 3F", 32'(v), 32'h00FF);
        read_reg(8'h14, v); chk("R10 ptr 14", 32'(v), 32'h41A0);
        // R7 one strobe per committed write
        for (int i = 0; i < NR; i++)
            chk("R7 strobe count", 32'(stb_cnt[i] - s0[i]), 32'(i == 1 ? 0 : 1));

        // R4 commit only at stop
        write_reg(8'h15, 16'h2468, 1'b0, acks);
        bw(H);
        chk("R4 before stop", 32'(reg_q[32 +: 16]), 32'hBEEF);
        bus_stop();
        chk("R4 after stop", 32'(reg_q[32 +: 16]), 32'h2468);

        // R5 truncated write
        for (int i = 0; i < NR; i++) s0[i] = stb_cnt[i];
        bus_start();
        send_byte(AW, a); send_byte(8'h15, a); send_byte(8'h99, a);
        bus_stop();
        chk("R5 unchanged", 32'(reg_q[32 +: 16]), 32'h2468);
        chk("R5 no strobe", 32'(stb_cnt[2] - s0[2]), 32'd0);

        // R2 foreign address
        bus_start();
        send_byte(8'h22, a);
        chk("R2 foreign nack", 32'(a), 32'd0);
        send_byte(8'h14, a);
        chk("R2 ignored byte nack", 32'(a), 32'd0);
        bus_stop();
        chk("R2 reg untouched", 32'(reg_q[16 +: 16]), 32'h41A0);

        // R9 unmapped pointer
        write_reg(8'h20, 16'hDEAD, 1'b1, acks);
        chk("R9 acked", 32'(acks), 32'hF);
        chk("R9 no change", 32'(reg_q == {16'h00FF, 16'h8001, 16'h2468, 16'h41A0, 16'h1357}), 32'd1);
        read_reg(8'h20, v);
        chk("R9 read zero", 32'(v), 32'h0000);

        // R6 surplus data byte
        bus_start();
        send_byte(AW, a); send_byte(8'h3E, a);
        send_byte(8'h34, a); send_byte(8'h12, a);
        pend_ok = 1'b1; pend_ptr = 8'h3E; pend_val = 16'h1234;
        send_byte(8'h77, a);
        chk("R6 extra nack", 32'(a), 32'd0);
        bus_stop();
        chk("R6 value", 32'(reg_q[48 +: 16]), 32'h1234);

        // R11 repeated start commits
        write_reg(8'h12, 16'hCAFE, 1'b0, acks);
        bus_start();
        chk("R11 committed at rstart", 32'(reg_q[0 +: 16]), 32'hCAFE);
        send_byte(AW, a);
        chk("R11 address after rstart", 32'(a), 32'd1);
        bus_stop();

        // R12 start mid-byte abandons it
        bus_start();
        send_bits(AW, 4);
        write_reg(8'h3F, 16'h5AA5, 1'b1, acks);
        chk("R12 acks", 32'(acks), 32'hF);
        chk("R12 value", 32'(reg_q[64 +: 16]), 32'h5AA5);

        // R13 master refuses the low byte
        bus_start(); send_byte(AW, a); send_byte(8'h15, a); bus_stop();
        bus_start(); send_byte(AR, a);
        recv_byte(1'b0, b);
        chk("R13 low byte", 32'(b), 32'h68);
        recv_byte(1'b0, b);
        chk("R13 released", 32'(b), 32'hFF);
        bus_stop();

        bw(20);
        finish_sim();
    end

endmodule